// File: doc/BRIEF.md
# Oversampled Transient Duty-Increment Estimator

This block sits between a voltage-error ADC and the duty-ratio modulator of a switching converter controller. The ADC delivers four signed error samples per switching period, for example at 2 MHz for a 500 kHz switching rate. One sample position in each period feeds the slow regulation loop. The block forwards that sample unchanged to an external PID compensator. The other three positions feed a fast transient path. There, each sample is turned into a duty-ratio correction: a programmable gain times the change from the previous sample.

A correction counts only when its size falls inside a programmable window. Corrections smaller than the lower bound are treated as output ripple and dropped. Corrections larger than the upper bound are treated as noise and dropped. This stops a ripple-sized error change of about one ADC step (4 mV) from triggering the path. The corrections for each of the three positions are averaged over a pair of switching periods. All three averages are issued together once every second period, which smooths quantization error. A transient-active flag tells the modulator whether the most recent issue carried any non-zero correction. Gain and thresholds are written through a small synchronous register port. A write is held and takes effect at the next switching-period boundary, so one period never mixes settings.

Top module: `tdi_estimator`

## Requirements
- R1: Accepted samples (smp_vld high) are numbered by phase 0,1,2,3 in arrival order, and the first sample after reset has phase 0. Each phase-0 sample appears on pid_err with pid_vld high one clock after it is accepted. Samples of any other phase never raise pid_vld.
- R2: For a sample of phase 1, 2 or 3, the raw increment is gain × (sample − previously accepted sample of any phase). The previous sample is zero after reset. The result is saturated to ±(2^(DW−1)−1).
- R3: A run of equal error samples yields zero increments and leaves xact low.
- R4: A raw increment whose magnitude is below dmin counts as zero. A magnitude equal to dmin is kept.
- R5: A raw increment whose magnitude is above dmax counts as zero. A magnitude equal to dmax is kept.
- R6: Switching periods are grouped in pairs, starting with the first period after reset. For each phase k in 1..3, the gated increments of the two periods are summed. Their floor average, floor(sum/2), is issued on inc_vals bits [(k−1)·DW +: DW] as a signed value. inc_vld pulses for exactly one clock, two clocks after the phase-3 sample of the second period is accepted. At no other time does inc_vld go high.
- R7: At each issue, xact is set if any issued value is non-zero and cleared otherwise. Between issues, xact and inc_vals hold their values.
- R8: The register port writes on cfg_we. Address 0 is the gain (low GW bits of the data), address 1 is dmin, address 2 is dmax, and address 3 has no effect. A written value takes effect when the next phase-0 sample is accepted. The reset values are gain 0, dmin 0 and dmax 2^DW−1.
- R9: While in reset and just after it, pid_vld, inc_vld and xact are low and inc_vals is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Error sample valid |
| smp_err | input | EW | Signed output-voltage error sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 gain, 1 dmin, 2 dmax |
| cfg_wdata | input | DW | Register write data |
| pid_vld | output | 1 | Regulation sample valid |
| pid_err | output | EW | Phase-0 error sample for the PID compensator |
| inc_vld | output | 1 | One-clock pulse when new increments are issued |
| inc_vals | output | 3·DW | Three signed averaged duty increments, phase 1 in the low slice |
| xact | output | 1 | Transient active: the last issue had a non-zero increment |

## Verification
The bench goes after increments that land exactly on dmin and on dmax. A design with an off-by-one comparison would drop the boundary value or pass the one just outside it. Very steep error steps at full gain check symmetric saturation, where a wrapping multiplier would flip the sign of the correction. A write made halfway through a switching period must not change the remaining samples of that period. A write to the unused address must change nothing, and a design that decodes the address loosely would corrupt a threshold. Negative odd sums check floor averaging, and the pair grouping is checked by demanding inc_vld in exactly one cycle per two periods.

// File: rtl/tdi_pkg.sv
package tdi_pkg;
   typedef enum logic [1:0] {
      CFG_GAIN = 2'd0,
      CFG_DMIN = 2'd1,
      CFG_DMAX = 2'd2,
      CFG_NONE = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/tdi_phase.sv
// Sample phase tagging and switching-period pair tracking.
module tdi_phase #(
   parameter int NPH = 4,
   localparam int PHW = $clog2(NPH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_vld,
   output logic [PHW-1:0] phase,
   output logic           odd,
   output logic           cyc_start,
   output logic           win_end
);
   localparam logic [PHW-1:0] LAST = PHW'(NPH - 1);

   logic [PHW-1:0] phase_nx;

   generate
      if ((1 << PHW) == NPH) begin : g_wrap
         assign phase_nx = phase + 1'b1;
      end else begin : g_cmp
         assign phase_nx = (phase == LAST) ? '0 : phase + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         odd   <= 1'b0;
      end else if (smp_vld) begin
         phase <= phase_nx;
         if (phase == LAST) odd <= ~odd;
      end
   end

   assign cyc_start = smp_vld && (phase == '0);
   assign win_end   = smp_vld && (phase == LAST) && odd;
endmodule

// File: rtl/tdi_cfg.sv
// Held configuration registers, committed at a switching-period boundary.
module tdi_cfg
   import tdi_pkg::*;
#(
   parameter int DW = 12,
   parameter int GW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   input  logic          commit,
   output logic [GW-1:0] gain,
   output logic [DW-1:0] dmin,
   output logic [DW-1:0] dmax
);
   logic [GW-1:0] sh_gain;
   logic [DW-1:0] sh_dmin, sh_dmax;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_gain <= '0;
         sh_dmin <= '0;
         sh_dmax <= '1;
      end else if (we) begin
         case (cfg_sel_e'(addr))
            CFG_GAIN: sh_gain <= wdata[GW-1:0];
            CFG_DMIN: sh_dmin <= wdata;
            CFG_DMAX: sh_dmax <= wdata;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain <= '0;
         dmin <= '0;
         dmax <= '1;
      end else if (commit) begin
         gain <= sh_gain;
         dmin <= sh_dmin;
         dmax <= sh_dmax;
      end
   end
endmodule

// File: rtl/tdi_slope.sv
// Scaled sample difference, saturation and threshold window.
module tdi_slope #(
   parameter int EW = 10,
   parameter int DW = 12,
   parameter int GW = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [EW-1:0] smp_err,
   input  logic [GW-1:0]        gain,
   input  logic [DW-1:0]        dmin,
   input  logic [DW-1:0]        dmax,
   output logic signed [DW-1:0] inc
);
   localparam int PW = (EW + GW + 2 > DW + 1) ? EW + GW + 2 : DW + 1;
   localparam logic signed [PW-1:0] LIM  = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] NLIM = -LIM;

   logic signed [EW-1:0] prev_q;
   logic signed [EW:0]   diff;
   logic signed [PW-1:0] g_ext, d_ext, prod;
   logic signed [DW-1:0] raw;
   logic [DW-1:0]        mag;
   logic                 keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q <= '0;
      else if (smp_vld) prev_q <= smp_err;
   end

   assign diff  = {smp_err[EW-1], smp_err} - {prev_q[EW-1], prev_q};
   assign g_ext = {{(PW-GW){1'b0}}, gain};
   assign d_ext = {{(PW-EW-1){diff[EW]}}, diff};
   assign prod  = g_ext * d_ext;

   generate
      if (EW + GW <= DW - 1) begin : g_nosat
         assign raw = prod[DW-1:0];
      end else begin : g_sat
         always_comb begin
            if (prod > LIM)       raw = LIM[DW-1:0];
            else if (prod < NLIM) raw = NLIM[DW-1:0];
            else                  raw = prod[DW-1:0];
         end
      end
   endgenerate

   assign mag  = raw[DW-1] ? DW'(-raw) : raw;
   assign keep = (mag >= dmin) && (mag <= dmax);
   assign inc  = keep ? raw : '0;
endmodule

// File: rtl/tdi_avg.sv
// Per-phase pair summation and issue of floor averages.
module tdi_avg #(
   parameter int NPH = 4,
   parameter int DW  = 12,
   localparam int PHW = $clog2(NPH),
   localparam int NS  = NPH - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic [PHW-1:0]       phase,
   input  logic                 odd,
   input  logic                 win_end,
   input  logic signed [DW-1:0] inc,
   output logic [NS*DW-1:0]     inc_vals,
   output logic                 inc_vld,
   output logic                 xact
);
   logic          fire_q;
   logic [NS-1:0] nz;

   generate
      for (genvar k = 0; k < NS; k++) begin : g_slot
         logic signed [DW:0]   sum_q;
         logic signed [DW-1:0] out_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sum_q <= '0;
            end else if (smp_vld && (phase == PHW'(k + 1))) begin
               sum_q <= odd ? sum_q + {inc[DW-1], inc} : {inc[DW-1], inc};
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      out_q <= '0;
            else if (fire_q) out_q <= sum_q[DW:1];
         end

         assign nz[k] = |sum_q[DW:1];
         assign inc_vals[k*DW +: DW] = out_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fire_q  <= 1'b0;
         inc_vld <= 1'b0;
         xact    <= 1'b0;
      end else begin
         fire_q  <= win_end;
         inc_vld <= fire_q;
         if (fire_q) xact <= |nz;
      end
   end
endmodule

// File: rtl/tdi_estimator.sv
module tdi_estimator #(
   parameter int EW  = 10,
   parameter int DW  = 12,
   parameter int GW  = 6,
   parameter int NPH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  smp_vld,
   input  logic [EW-1:0]         smp_err,
   input  logic                  cfg_we,
   input  logic [1:0]            cfg_addr,
   input  logic [DW-1:0]         cfg_wdata,
   output logic                  pid_vld,
   output logic [EW-1:0]         pid_err,
   output logic                  inc_vld,
   output logic [(NPH-1)*DW-1:0] inc_vals,
   output logic                  xact
);
   localparam int PHW = $clog2(NPH);

   generate
      if (EW < 2)              begin : g_bad_ew  $error("EW must be at least 2"); end
      if (DW < 4)              begin : g_bad_dw  $error("DW must be at least 4"); end
      if (GW < 1 || GW > DW)   begin : g_bad_gw  $error("GW must lie in 1..DW"); end
      if (NPH < 2)             begin : g_bad_nph $error("NPH must be at least 2"); end
   endgenerate

   logic [PHW-1:0]       phase;
   logic                 odd, cyc_start, win_end;
   logic [GW-1:0]        gain;
   logic [DW-1:0]        dmin, dmax;
   logic signed [DW-1:0] inc;

   tdi_phase #(.NPH(NPH)) u_phase (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .phase(phase),
      .odd(odd), .cyc_start(cyc_start), .win_end(win_end)
   );

   tdi_cfg #(.DW(DW), .GW(GW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .commit(cyc_start),
      .gain(gain), .dmin(dmin), .dmax(dmax)
   );

   tdi_slope #(.EW(EW), .DW(DW), .GW(GW)) u_slope (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_err(smp_err),
      .gain(gain), .dmin(dmin), .dmax(dmax), .inc(inc)
   );

   tdi_avg #(.NPH(NPH), .DW(DW)) u_avg (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .phase(phase),
      .odd(odd), .win_end(win_end), .inc(inc),
      .inc_vals(inc_vals), .inc_vld(inc_vld), .xact(xact)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pid_vld <= 1'b0;
         pid_err <= '0;
      end else begin
         pid_vld <= cyc_start;
         if (cyc_start) pid_err <= smp_err;
      end
   end
endmodule

// File: rtl/tdi_chk.sv
module tdi_chk #(
   parameter int EW  = 10,
   parameter int DW  = 12,
   parameter int NPH = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  smp_vld,
   input logic [EW-1:0]         smp_err,
   input logic                  pid_vld,
   input logic [EW-1:0]         pid_err,
   input logic                  inc_vld,
   input logic [(NPH-1)*DW-1:0] inc_vals,
   input logic                  xact
);
   AST_PID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      pid_vld |-> $past(smp_vld)); // R1
   AST_PID_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pid_vld |-> pid_err == $past(smp_err)); // R1
   AST_INC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      inc_vld |=> !inc_vld); // R6
   AST_INC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      inc_vld |-> $past(smp_vld, 2)); // R6
   AST_XACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_vld |-> $stable(xact)); // R7
   AST_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_vld |-> $stable(inc_vals)); // R7

   generate
      for (genvar k = 0; k < NPH - 1; k++) begin : g_bound
         AST_INC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            inc_vals[k*DW +: DW] != {1'b1, {(DW-1){1'b0}}}); // R2
      end
   endgenerate
endmodule

bind tdi_estimator tdi_chk #(.EW(EW), .DW(DW), .NPH(NPH)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_err(smp_err),
   .pid_vld(pid_vld), .pid_err(pid_err), .inc_vld(inc_vld),
   .inc_vals(inc_vals), .xact(xact)
);

// File: tb/tb_tdi_estimator.sv
`timescale 1ns/1ps
module tb_tdi_estimator;
   localparam int EW = 10, DW = 12, GW = 6, NPH = 4;
   localparam int LIM = 2047;

   logic clk = 1'b0, rst_n = 1'b0;
   logic smp_vld = 1'b0, cfg_we = 1'b0;
   logic [EW-1:0] smp_err = '0;
   logic [1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic pid_vld, inc_vld, xact;
   logic [EW-1:0] pid_err;
   logic [3*DW-1:0] inc_vals;

   always #4 clk = ~clk;

   tdi_estimator #(.EW(EW), .DW(DW), .GW(GW), .NPH(NPH)) dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_err(smp_err),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .pid_vld(pid_vld), .pid_err(pid_err), .inc_vld(inc_vld),
      .inc_vals(inc_vals), .xact(xact)
   );

   int n_chk = 0, n_bad = 0;
   int m_phase = 0, m_odd = 0, m_prev = 0;
   int s_gain = 0, s_dmin = 0, s_dmax = 4095;
   int a_gain = 0, a_dmin = 0, a_dmax = 4095;
   int m_sum [1:3];
   int exp_inc [1:3];
   int exp_xact = 0;

   task automatic chk(input bit ok, input string tag, input int got, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, expv);
      end
   endtask

   function automatic int ref_inc(input int e, input int p);
      int v, m;
      v = a_gain * (e - p);
      if (v > LIM) v = LIM;
      if (v < -LIM) v = -LIM;
      m = (v < 0) ? -v : v;
      if (m < a_dmin || m > a_dmax) return 0;
      return v;
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a[1:0]; cfg_wdata = d[DW-1:0];
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      case (a)
         0: s_gain = d & 63;
         1: s_dmin = d;
         2: s_dmax = d;
         default: ;
      endcase
   endtask

   task automatic send(input int e, input string tag);
      bit pid_exp, fire;
      int g, got;
      @(negedge clk);
      smp_vld = 1'b1; smp_err = e[EW-1:0];
      fire = 1'b0;
      pid_exp = (m_phase == 0);
      if (m_phase == 0) begin
         a_gain = s_gain; a_dmin = s_dmin; a_dmax = s_dmax;
      end else begin
         g = ref_inc(e, m_prev);
         if (m_odd == 0) m_sum[m_phase] = g;
         else m_sum[m_phase] = m_sum[m_phase] + g;
      end
      m_prev = e;
      if (m_phase == 3) begin
         if (m_odd == 1) fire = 1'b1;
         m_odd = 1 - m_odd;
      end
      m_phase = (m_phase + 1) % 4;
      if (fire) begin
         exp_xact = 0;
         for (int k = 1; k <= 3; k++) begin
            exp_inc[k] = m_sum[k] >>> 1;
            if (exp_inc[k] != 0) exp_xact = 1;
         end
      end
      @(posedge clk);
      @(negedge clk);
      smp_vld = 1'b0;
      chk(pid_vld == pid_exp, "R1 pid_vld", int'(pid_vld), int'(pid_exp));
      if (pid_exp) chk(int'($signed(pid_err)) == e, "R1 pid_err", int'($signed(pid_err)), e);
      @(posedge clk);
      @(negedge clk);
      chk(inc_vld == fire, "R6 inc_vld", int'(inc_vld), int'(fire));
      for (int k = 1; k <= 3; k++) begin
         got = int'($signed(inc_vals[(k-1)*DW +: DW]));
         chk(got == exp_inc[k], tag, got, exp_inc[k]);
      end
      chk(int'(xact) == exp_xact, "R7 xact", int'(xact), exp_xact);
   endtask

   task automatic window(input int e0, input int e1, input int e2, input int e3,
                         input int e4, input int e5, input int e6, input int e7,
                         input string tag);
      send(e0, tag); send(e1, tag); send(e2, tag); send(e3, tag);
      send(e4, tag); send(e5, tag); send(e6, tag); send(e7, tag);
   endtask

   task automatic finish_run;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R6 got=timeout exp=done");
      finish_run();
   end

   initial begin
      int e, w;
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      for (int k = 1; k <= 3; k++) begin m_sum[k] = 0; exp_inc[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      chk(pid_vld == 1'b0, "R9 pid_vld", int'(pid_vld), 0);
      chk(inc_vld == 1'b0, "R9 inc_vld", int'(inc_vld), 0);
      chk(xact == 1'b0, "R9 xact", int'(xact), 0);
      chk(inc_vals == '0, "R9 inc_vals", int'(inc_vals != '0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(inc_vld == 1'b0 && xact == 1'b0, "R9 after release", int'(inc_vld | xact), 0);

      // R8: reset gain is zero, so a ramp gives nothing
      window(0, 50, 100, 150, 200, 250, 300, 350, "R8 reset gain");
      // R3: constant error with non-zero gain
      wr(0, 3);
      window(20, 20, 20, 20, 20, 20, 20, 20, "R3 steady");
      // R2/R6: ramp with odd sums, including negative steps
      window(0, 5, 10, 16, -1, -3, 4, 2, "R6 average");
      window(2, -5, 0, 7, 7, -6, 1, 1, "R2 signed diff");
      // R4: dmin boundary, 15 kept and 12 dropped
      wr(1, 15);
      window(0, 0, 5, 9, 13, 13, 18, 22, "R4 dmin");
      window(22, 17, 12, 8, 8, 3, -1, -6, "R4 dmin neg");
      // R5: dmax boundary, 30 kept and 33 dropped
      wr(1, 0);
      wr(2, 30);
      window(0, 10, 21, 31, 31, 20, 10, -1, "R5 dmax");
      // R2: saturation at full gain
      wr(0, 63);
      wr(2, 4095);
      window(0, 500, -500, 511, -512, 511, -512, 0, "R2 saturate");
      // R8: write in mid-period applies at the next phase-0 sample; address 3 ignored
      wr(0, 2);
      send(0, "R8 timing"); send(4, "R8 timing");
      wr(0, 5);
      wr(3, 7);
      send(9, "R8 timing"); send(15, "R8 timing");
      send(15, "R8 timing"); send(21, "R8 timing");
      wr(3, 4095);
      send(30, "R8 timing"); send(30, "R8 timing");
      // R7: a quiet window after activity clears xact
      window(30, 30, 30, 30, 30, 30, 30, 30, "R7 clear");

      // random mix
      e = 0;
      for (int wi = 0; wi < 60; wi++) begin
         if ($urandom_range(3) == 0) wr(0, int'($urandom_range(63)));
         if ($urandom_range(4) == 0) wr(1, int'($urandom_range(200)));
         if ($urandom_range(4) == 0) wr(2, int'($urandom_range(4095)));
         if ($urandom_range(7) == 0) wr(3, int'($urandom_range(4095)));
         for (int si = 0; si < 8; si++) begin
            if ($urandom_range(9) == 0) w = int'($urandom_range(1023)) - 512;
            else w = e + int'($urandom_range(60)) - 30;
            if (w > 511) w = 511;
            if (w < -512) w = -512;
            e = w;
            send(e, "R6 random");
         end
      end
      finish_run();
   end
endmodule